// File: doc/BRIEF.md
# Multi-Bank SDRAM Command State Tracker

This block sits on the device side of a double-data-rate SDRAM command bus. On every rising clock edge it looks at the clock-enable, chip-select, row strobe, column strobe, write-enable, bank-select and address pins. It turns them into a command and keeps an exact picture of the device: one overall device state and a separate state for each of four banks, together with the row each bank holds open.

Commands that the current state does not allow are refused. A refused command leaves the state as it was and raises a one-cycle error pulse. The block is meant for a memory model, for a protocol monitor, or as the command front end of a device-side controller. Data transfer, refresh interval timing and electrical behaviour are out of its scope.

Read and write bursts last a number of clock cycles set by the burst-length field of the standard mode register. A bank that was opened with auto-precharge closes by itself once its burst ends. Power-down, self refresh and deep power-down are entered on a falling clock-enable and left when clock-enable goes high again.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, dev_state is 0 and every bank_state field is 0. bank_open and cmd_err are 0, mode_std is 3 and mode_ext is 0. dev_state codes are 0 ready, 1 precharge power-down, 2 active power-down, 3 auto refresh, 4 self refresh, 5 deep power-down and 6 mode load. Each bank takes a 3-bit field at bank_state[3b+2:3b], with codes 0 idle, 1 row active, 2 reading, 3 writing and 4 precharging.
- R2: A cycle with cs_n high is a deselect and changes nothing. A NOP (cs_n low, ras_n, cas_n and we_n high) also changes nothing and is never an error.
- R3: ACTIVE (cs_n=0, ras_n=0, cas_n=1, we_n=1) to an idle bank moves only that bank to row active. It stores addr into that bank's bank_row field and sets its bank_open bit. Banks are tracked independently.
- R4: READ (ras_n=1, cas_n=0, we_n=1) or WRITE (ras_n=1, cas_n=0, we_n=0) to a row-active bank holds it in reading or writing for a number of cycles. That number is 1, 2, 4 or 8 for mode_std[2:0] = 1, 2, 3 or 4, and 1 for any other value. Without auto-precharge the bank then returns to row active.
- R5: When addr[10] is high on READ or WRITE, the bank goes to precharging after the burst, stays there for PRE_CYC cycles (default 2) and then returns to idle.
- R6: BURST STOP (ras_n=1, cas_n=1, we_n=0) moves every bank that is reading without auto-precharge back to row active in the next cycle.
- R7: PRECHARGE (ras_n=0, cas_n=1, we_n=0) with addr[10] low moves the addressed row-active bank to precharging. With addr[10] high it moves every row-active bank to precharging at once. After PRE_CYC cycles each such bank is idle.
- R8: MODE LOAD (ras_n=0, cas_n=0, we_n=0) with all banks idle writes addr into mode_std when ba=0 and into mode_ext when ba=1, and holds dev_state at 6 for MRD_CYC cycles (default 2).
- R9: REFRESH (ras_n=0, cas_n=0, we_n=1) with clock enable high and all banks idle holds dev_state at 3 for RFC_CYC cycles (default 4), then ready.
- R10: Clock enable falling with a NOP or deselect enters state 1 if all banks are idle, or state 2 if banks are only idle or row active. While clock enable stays low, all bank states are frozen. Clock enable high returns to ready with bank states and rows kept.
- R11: Clock enable falling with REFRESH enters self refresh (4), and with BURST STOP enters deep power-down (5), both only with all banks idle. Clock enable high returns to ready.
- R12: A command not legal in the current state raises cmd_err for exactly the next cycle and changes no state. Illegal cases include: ACTIVE to an open bank; READ to an idle bank; REFRESH, MODE LOAD or a power-down entry while banks are busy; BURST STOP with no read running; MODE LOAD with ba of 2 or 3.
- R13: Any command other than NOP or deselect during auto refresh or mode load is an error. Commands issued during a power-down state are ignored without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row or column address; bit 10 selects auto-precharge or all banks |
| dev_state | output | 3 | Device state code |
| bank_state | output | 12 | Packed 3-bit state per bank |
| bank_open | output | 4 | One bit per bank holding an open row |
| bank_row | output | 52 | Packed 13-bit open row per bank |
| mode_std | output | 13 | Standard mode register contents |
| mode_ext | output | 13 | Extended mode register contents |
| cmd_err | output | 1 | One-cycle illegal-command pulse |

## Verification
Every output is a register. The result of a command sampled at one rising edge is therefore due in the half cycle right after that edge. The bench drives pins on the falling edge and compares on the next falling edge, one clock later. Timed states are checked on each cycle of their window: a burst of N cycles shows reading or writing for exactly N checks, then precharging for PRE_CYC checks, and auto refresh and mode load show for RFC_CYC and MRD_CYC checks. The sweep repeats this for every bank, every burst length, both directions and both auto-precharge settings. Each error pulse is checked in the cycle after the offending command and found clear one cycle later.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    DEV_READY  = 3'd0,
    DEV_PD_PRE = 3'd1,
    DEV_PD_ACT = 3'd2,
    DEV_AREF   = 3'd3,
    DEV_SREF   = 3'd4,
    DEV_DPD    = 3'd5,
    DEV_MODE   = 3'd6
  } dev_state_e;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_ACTIVE = 3'd1,
    BK_READ   = 3'd2,
    BK_WRITE  = 3'd3,
    BK_PRECH  = 3'd4
  } bank_state_e;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE,
    CMD_BST, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_ACT, OP_RD, OP_WR, OP_STOP, OP_PRE
  } bank_op_e;

  // Burst length code from mode bits [2:0] to burst duration in clocks.
  function automatic logic [3:0] burst_cycles(input logic [2:0] code);
    case (code)
      3'd2:    burst_cycles = 4'd2;
      3'd3:    burst_cycles = 4'd4;
      3'd4:    burst_cycles = 4'd8;
      default: burst_cycles = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int PRE_CYC = 2,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  bank_op_e           op,
  input  logic [ROW_W-1:0]   row_in,
  input  logic               auto_in,
  input  logic [CNT_W-1:0]   burst_cyc,
  output bank_state_e        state_o,
  output logic [ROW_W-1:0]   row_o,
  output logic               open_o,
  output logic               auto_o
);

  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC);

  bank_state_e       st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              auto_n;
  logic [ROW_W-1:0]  row_n;

  always_comb begin
    st_n   = state_o;
    cnt_n  = cnt_q;
    auto_n = auto_o;
    row_n  = row_o;
    case (state_o)
      BK_IDLE: begin
        if (op == OP_ACT) begin
          st_n  = BK_ACTIVE;
          row_n = row_in;
        end
      end
      BK_ACTIVE: begin
        if (op == OP_RD || op == OP_WR) begin
          st_n   = (op == OP_RD) ? BK_READ : BK_WRITE;
          cnt_n  = burst_cyc;
          auto_n = auto_in;
        end else if (op == OP_PRE) begin
          st_n  = BK_PRECH;
          cnt_n = PRE_LD;
        end
      end
      BK_READ, BK_WRITE: begin
        if (op == OP_RD || op == OP_WR) begin
          st_n   = (op == OP_RD) ? BK_READ : BK_WRITE;
          cnt_n  = burst_cyc;
          auto_n = auto_in;
        end else if (op == OP_STOP) begin
          st_n = BK_ACTIVE;
        end else if (cnt_q <= CNT_W'(1)) begin
          if (auto_o) begin
            st_n  = BK_PRECH;
            cnt_n = PRE_LD;
          end else begin
            st_n = BK_ACTIVE;
          end
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      BK_PRECH: begin
        if (cnt_q <= CNT_W'(1)) st_n = BK_IDLE;
        else                    cnt_n = cnt_q - CNT_W'(1);
      end
      default: st_n = BK_IDLE;
    endcase
    if (st_n != BK_READ && st_n != BK_WRITE) auto_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= BK_IDLE;
      cnt_q   <= '0;
      auto_o  <= 1'b0;
      row_o   <= '0;
      open_o  <= 1'b0;
    end else begin
      state_o <= st_n;
      cnt_q   <= cnt_n;
      auto_o  <= auto_n;
      row_o   <= row_n;
      open_o  <= (st_n == BK_ACTIVE) || (st_n == BK_READ) || (st_n == BK_WRITE);
    end
  end

endmodule

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NB       = 4,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int AP_BIT   = 10,
  parameter int MRD_CYC  = 2,
  parameter int RFC_CYC  = 4,
  parameter int CNT_W    = 4,
  parameter logic [ROW_W-1:0] STD_RST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  cmd_e              cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ROW_W-1:0]  addr,
  input  bank_state_e       bank_st   [NB],
  input  logic              bank_auto [NB],
  output bank_op_e          bank_op   [NB],
  output logic              auto_req,
  output logic [CNT_W-1:0]  burst_cyc,
  output dev_state_e        dev_q,
  output logic [ROW_W-1:0]  mode_std,
  output logic [ROW_W-1:0]  mode_ext,
  output logic              cmd_err
);

  localparam int DMAX   = (MRD_CYC > RFC_CYC) ? MRD_CYC : RFC_CYC;
  localparam int DCNT_W = $clog2(DMAX + 1);

  dev_state_e        dev_n;
  logic [DCNT_W-1:0] dcnt_q, dcnt_n;
  logic              cke_q;
  logic              illegal, std_we, ext_we;
  logic              all_idle, none_busy, any_burst, any_stop;
  bank_state_e       cur;

  assign auto_req  = addr[AP_BIT];
  assign burst_cyc = CNT_W'(burst_cycles(mode_std[2:0]));
  assign cur       = bank_st[ba];

  always_comb begin
    all_idle  = 1'b1;
    none_busy = 1'b1;
    any_burst = 1'b0;
    any_stop  = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (bank_st[i] != BK_IDLE) all_idle = 1'b0;
      if (bank_st[i] != BK_IDLE && bank_st[i] != BK_ACTIVE) none_busy = 1'b0;
      if (bank_st[i] == BK_READ || bank_st[i] == BK_WRITE) any_burst = 1'b1;
      if (bank_st[i] == BK_READ && !bank_auto[i]) any_stop = 1'b1;
    end
  end

  always_comb begin
    dev_n   = dev_q;
    dcnt_n  = dcnt_q;
    illegal = 1'b0;
    std_we  = 1'b0;
    ext_we  = 1'b0;
    for (int i = 0; i < NB; i++) bank_op[i] = OP_NONE;
    case (dev_q)
      DEV_READY: begin
        if (cke_q && cke) begin
          case (cmd)
            CMD_ACT: begin
              if (cur == BK_IDLE) bank_op[ba] = OP_ACT;
              else                illegal = 1'b1;
            end
            CMD_READ, CMD_WRITE: begin
              if (cur == BK_ACTIVE ||
                  ((cur == BK_READ || cur == BK_WRITE) && !bank_auto[ba]))
                bank_op[ba] = (cmd == CMD_READ) ? OP_RD : OP_WR;
              else
                illegal = 1'b1;
            end
            CMD_BST: begin
              if (any_stop) begin
                for (int i = 0; i < NB; i++)
                  if (bank_st[i] == BK_READ && !bank_auto[i]) bank_op[i] = OP_STOP;
              end else begin
                illegal = 1'b1;
              end
            end
            CMD_PRE: begin
              if (addr[AP_BIT]) begin
                if (any_burst) illegal = 1'b1;
                else
                  for (int i = 0; i < NB; i++)
                    if (bank_st[i] == BK_ACTIVE) bank_op[i] = OP_PRE;
              end else begin
                if (cur == BK_READ || cur == BK_WRITE) illegal = 1'b1;
                else if (cur == BK_ACTIVE)             bank_op[ba] = OP_PRE;
              end
            end
            CMD_REF: begin
              if (all_idle) begin
                dev_n  = DEV_AREF;
                dcnt_n = DCNT_W'(RFC_CYC);
              end else begin
                illegal = 1'b1;
              end
            end
            CMD_MRS: begin
              if (all_idle && ba < BA_W'(2)) begin
                dev_n  = DEV_MODE;
                dcnt_n = DCNT_W'(MRD_CYC);
                std_we = (ba == BA_W'(0));
                ext_we = (ba == BA_W'(1));
              end else begin
                illegal = 1'b1;
              end
            end
            default: ;
          endcase
        end else if (cke_q && !cke) begin
          case (cmd)
            CMD_NOP, CMD_DESEL: begin
              if (all_idle)       dev_n = DEV_PD_PRE;
              else if (none_busy) dev_n = DEV_PD_ACT;
              else                illegal = 1'b1;
            end
            CMD_REF: begin
              if (all_idle) dev_n = DEV_SREF;
              else          illegal = 1'b1;
            end
            CMD_BST: begin
              if (all_idle) dev_n = DEV_DPD;
              else          illegal = 1'b1;
            end
            default: illegal = 1'b1;
          endcase
        end
      end
      DEV_AREF, DEV_MODE: begin
        if (dcnt_q <= DCNT_W'(1)) dev_n = DEV_READY;
        else                      dcnt_n = dcnt_q - DCNT_W'(1);
        if (cmd != CMD_NOP && cmd != CMD_DESEL) illegal = 1'b1;
      end
      default: begin
        if (cke) dev_n = DEV_READY;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q    <= DEV_READY;
      dcnt_q   <= '0;
      cke_q    <= 1'b1;
      mode_std <= STD_RST;
      mode_ext <= '0;
      cmd_err  <= 1'b0;
    end else begin
      dev_q   <= dev_n;
      dcnt_q  <= dcnt_n;
      cke_q   <= cke;
      cmd_err <= illegal;
      if (std_we) mode_std <= addr;
      if (ext_we) mode_ext <= addr;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int AP_BIT    = 10,
  parameter int PRE_CYC   = 2,
  parameter int MRD_CYC   = 2,
  parameter int RFC_CYC   = 4,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int ST_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BA_W-1:0]               ba,
  input  logic [ROW_W-1:0]              addr,
  output logic [2:0]                    dev_state,
  output logic [NUM_BANKS*ST_W-1:0]     bank_state,
  output logic [NUM_BANKS-1:0]          bank_open,
  output logic [NUM_BANKS*ROW_W-1:0]    bank_row,
  output logic [ROW_W-1:0]              mode_std,
  output logic [ROW_W-1:0]              mode_ext,
  output logic                          cmd_err
);

  localparam int TMAX  = (PRE_CYC > 8) ? PRE_CYC : 8;
  localparam int CNT_W = $clog2(TMAX + 1);

  cmd_e              cmd;
  bank_state_e       bank_st   [NUM_BANKS];
  logic              bank_auto [NUM_BANKS];
  bank_op_e          bank_op   [NUM_BANKS];
  logic              auto_req;
  logic [CNT_W-1:0]  burst_cyc;
  dev_state_e        dev_q;

  sdram_trk_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdram_trk_ctrl #(
    .NB      (NUM_BANKS),
    .BA_W    (BA_W),
    .ROW_W   (ROW_W),
    .AP_BIT  (AP_BIT),
    .MRD_CYC (MRD_CYC),
    .RFC_CYC (RFC_CYC),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cmd       (cmd),
    .ba        (ba),
    .addr      (addr),
    .bank_st   (bank_st),
    .bank_auto (bank_auto),
    .bank_op   (bank_op),
    .auto_req  (auto_req),
    .burst_cyc (burst_cyc),
    .dev_q     (dev_q),
    .mode_std  (mode_std),
    .mode_ext  (mode_ext),
    .cmd_err   (cmd_err)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_trk_bank #(
      .ROW_W   (ROW_W),
      .PRE_CYC (PRE_CYC),
      .CNT_W   (CNT_W)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .op        (bank_op[g]),
      .row_in    (addr),
      .auto_in   (auto_req),
      .burst_cyc (burst_cyc),
      .state_o   (bank_st[g]),
      .row_o     (bank_row[g*ROW_W +: ROW_W]),
      .open_o    (bank_open[g]),
      .auto_o    (bank_auto[g])
    );
    assign bank_state[g*ST_W +: ST_W] = bank_st[g];
  end

  assign dev_state = dev_q;

endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk
  import sdram_trk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic [2:0]        dev_state,
  input logic [NB*3-1:0]   bank_state,
  input logic [NB-1:0]     bank_open,
  input logic [ROW_W-1:0]  mode_std,
  input logic [ROW_W-1:0]  mode_ext,
  input logic              cmd_err
);

  logic in_pd;
  assign in_pd = (dev_state == 3'(DEV_PD_PRE)) || (dev_state == 3'(DEV_PD_ACT)) ||
                 (dev_state == 3'(DEV_SREF))   || (dev_state == 3'(DEV_DPD));

  // R12: an error only follows a selected command or a falling clock enable
  p_err_cause_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(!cs_n || !cke));

  // R2: a deselected cycle never touches the mode registers
  p_masked_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(mode_std) && $stable(mode_ext)));

  // R10: clock enable high leaves any power-down state
  p_pd_exit_r10: assert property (@(posedge clk) disable iff (rst)
    (in_pd && cke) |=> (dev_state == 3'(DEV_READY)));

  // R10: while clock enable stays low banks are frozen and no error is raised
  p_pd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (in_pd && !cke) |=> ($stable(bank_state) && !cmd_err));

  // R9: auto refresh is only entered with all banks idle
  p_ref_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (dev_state == 3'(DEV_AREF) && $past(dev_state) == 3'(DEV_READY))
      |-> ($past(bank_state) == '0));

  // R8: mode load is only entered with all banks idle
  p_mrs_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (dev_state == 3'(DEV_MODE) && $past(dev_state) == 3'(DEV_READY))
      |-> ($past(bank_state) == '0));

  for (genvar i = 0; i < NB; i++) begin : g_bk
    // R3: a row only opens on a bank that was idle
    p_open_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(bank_open[i]) |-> ($past(bank_state[i*3 +: 3]) == 3'(BK_IDLE)));
  end

endmodule

bind sdram_cmd_tracker sdram_trk_chk #(
  .NB    (NUM_BANKS),
  .ROW_W (ROW_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cke        (cke),
  .cs_n       (cs_n),
  .dev_state  (dev_state),
  .bank_state (bank_state),
  .bank_open  (bank_open),
  .mode_std   (mode_std),
  .mode_ext   (mode_ext),
  .cmd_err    (cmd_err)
);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;

  localparam int NB  = 4;
  localparam int RW  = 13;
  localparam int PRE = 2;
  localparam int MRD = 2;
  localparam int RFC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [RW-1:0] addr = '0;
  logic [2:0] dev_state;
  logic [NB*3-1:0] bank_state;
  logic [NB-1:0] bank_open;
  logic [NB*RW-1:0] bank_row;
  logic [RW-1:0] mode_std, mode_ext;
  logic cmd_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_tracker #(
    .NUM_BANKS (NB), .ROW_W (RW), .AP_BIT (10),
    .PRE_CYC (PRE), .MRD_CYC (MRD), .RFC_CYC (RFC)
  ) i_sdram_cmd_tracker (
    .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
    .dev_state (dev_state), .bank_state (bank_state), .bank_open (bank_open),
    .bank_row (bank_row), .mode_std (mode_std), .mode_ext (mode_ext),
    .cmd_err (cmd_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] bs(input int b);
    return bank_state[b*3 +: 3];
  endfunction

  function automatic logic [RW-1:0] brow(input int b);
    return bank_row[b*RW +: RW];
  endfunction

  task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                       input logic [1:0] b, input logic [RW-1:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();                                    drive(0, 1, 1, 1, 2'd0, '0);  endtask
  task automatic act(input logic [1:0] b, input logic [RW-1:0] r); drive(0, 0, 1, 1, b, r); endtask
  task automatic rd(input logic [1:0] b, input logic ap);  drive(0, 1, 0, 1, b, RW'({ap, 10'd0})); endtask
  task automatic wr(input logic [1:0] b, input logic ap);  drive(0, 1, 0, 0, b, RW'({ap, 10'd0})); endtask
  task automatic bst();                                    drive(0, 1, 1, 0, 2'd0, '0);  endtask
  task automatic pre(input logic [1:0] b, input logic all); drive(0, 0, 1, 0, b, RW'({all, 10'd0})); endtask
  task automatic refc();                                   drive(0, 0, 0, 1, 2'd0, '0);  endtask
  task automatic mrs(input logic [1:0] b, input logic [RW-1:0] v); drive(0, 0, 0, 0, b, v); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int bl;
    logic [RW-1:0] row;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 dev_state", 32'(dev_state), 0);
    chk("R1 bank_state", 32'(bank_state), 0);
    chk("R1 bank_open", 32'(bank_open), 0);
    chk("R1 cmd_err", 32'(cmd_err), 0);
    chk("R1 mode_std", 32'(mode_std), 3);
    chk("R1 mode_ext", 32'(mode_ext), 0);

    // Sweep: every burst code, bank, direction and auto-precharge setting (R4 R5 R7 R8 R3)
    for (int code = 1; code <= 4; code++) begin
      bl = 1 << (code - 1);
      mrs(2'd0, RW'(code));
      chk("R8 mode load state", 32'(dev_state), 6);
      chk("R8 mode_std written", 32'(mode_std), 32'(code));
      for (int k = 1; k < MRD; k++) begin
        nop();
        chk("R8 mode load hold", 32'(dev_state), 6);
      end
      nop();
      chk("R8 mode load done", 32'(dev_state), 0);
      for (int b = 0; b < NB; b++) begin
        for (int w = 0; w < 2; w++) begin
          for (int ap = 0; ap < 2; ap++) begin
            row = RW'(code * 97 + b * 31 + w * 7 + ap + 1);
            act(2'(b), row);
            chk("R3 bank active", 32'(bs(b)), 1);
            chk("R3 row stored", 32'(brow(b)), 32'(row));
            chk("R3 open bit", 32'(bank_open), 32'(1 << b));
            if (w == 1) wr(2'(b), ap[0]);
            else        rd(2'(b), ap[0]);
            for (int j = 0; j < bl; j++) begin
              if (j > 0) nop();
              chk("R4 burst state", 32'(bs(b)), (w == 1) ? 3 : 2);
            end
            nop();
            if (ap == 1) begin
              chk("R5 auto precharge", 32'(bs(b)), 4);
              chk("R5 row closed", 32'(bank_open), 0);
              for (int k = 1; k < PRE; k++) begin
                nop();
                chk("R5 precharge hold", 32'(bs(b)), 4);
              end
              nop();
              chk("R5 back to idle", 32'(bs(b)), 0);
            end else begin
              chk("R4 back to active", 32'(bs(b)), 1);
              pre(2'(b), 1'b0);
              chk("R7 single precharge", 32'(bs(b)), 4);
              for (int k = 1; k < PRE; k++) begin
                nop();
                chk("R7 precharge hold", 32'(bs(b)), 4);
              end
              nop();
              chk("R7 idle after precharge", 32'(bs(b)), 0);
            end
            chk("R3 other banks untouched", 32'(bank_state), 0);
          end
        end
      end
    end

    // R2: deselected cycles and NOP change nothing
    drive(1, 0, 0, 0, 2'd0, 13'h0055);
    chk("R2 masked mode load", 32'(mode_std), 4);
    chk("R2 masked dev_state", 32'(dev_state), 0);
    drive(1, 0, 1, 1, 2'd2, 13'h0005);
    chk("R2 masked activate", 32'(bank_state), 0);
    nop();
    chk("R2 nop no error", 32'(cmd_err), 0);
    chk("R2 nop no change", 32'(bank_state), 0);

    // R3: two banks open independently
    act(2'd0, 13'h0123);
    act(2'd2, 13'h1abc);
    chk("R3 bank0 row", 32'(brow(0)), 32'h123);
    chk("R3 bank2 row", 32'(brow(2)), 32'h1abc);
    chk("R3 open mask", 32'(bank_open), 32'b0101);
    chk("R3 bank1 idle", 32'(bs(1)), 0);

    // R12: illegal commands
    act(2'd0, 13'h0777);
    chk("R12 err on reactivate", 32'(cmd_err), 1);
    chk("R12 row kept", 32'(brow(0)), 32'h123);
    nop();
    chk("R12 err one cycle", 32'(cmd_err), 0);
    rd(2'd1, 1'b0);
    chk("R12 err read idle", 32'(cmd_err), 1);
    chk("R12 idle kept", 32'(bs(1)), 0);
    refc();
    chk("R12 err refresh busy", 32'(cmd_err), 1);
    chk("R12 dev kept", 32'(dev_state), 0);
    mrs(2'd0, 13'h0001);
    chk("R12 err mode load busy", 32'(cmd_err), 1);
    chk("R12 mode kept", 32'(mode_std), 4);

    // R10: active power-down keeps banks
    cke = 1'b0;
    nop();
    chk("R10 active power-down", 32'(dev_state), 2);
    act(2'd1, 13'h0005);
    chk("R13 ignored in power-down", 32'(bs(1)), 0);
    chk("R13 no error in power-down", 32'(cmd_err), 0);
    cke = 1'b1;
    nop();
    chk("R10 exit to ready", 32'(dev_state), 0);
    chk("R10 bank0 kept", 32'(bs(0)), 1);
    chk("R10 row kept", 32'(brow(0)), 32'h123);

    // R6: burst stop
    rd(2'd0, 1'b0);
    chk("R6 reading", 32'(bs(0)), 2);
    nop();
    chk("R6 still reading", 32'(bs(0)), 2);
    bst();
    chk("R6 stopped", 32'(bs(0)), 1);
    nop();
    chk("R6 stays active", 32'(bs(0)), 1);
    bst();
    chk("R12 err stop without read", 32'(cmd_err), 1);

    // R7: precharge all
    pre(2'd1, 1'b1);
    chk("R7 all bank0", 32'(bs(0)), 4);
    chk("R7 all bank2", 32'(bs(2)), 4);
    nop();
    chk("R7 all hold", 32'(bank_state), 32'h104);
    nop();
    chk("R7 all idle", 32'(bank_state), 0);

    // R10: precharge power-down
    cke = 1'b0;
    nop();
    chk("R10 precharge power-down", 32'(dev_state), 1);
    nop();
    chk("R10 hold power-down", 32'(dev_state), 1);
    cke = 1'b1;
    nop();
    chk("R10 exit precharge power-down", 32'(dev_state), 0);

    // R9 and R13: auto refresh
    refc();
    chk("R9 auto refresh", 32'(dev_state), 3);
    act(2'd0, 13'h0001);
    chk("R13 err during refresh", 32'(cmd_err), 1);
    chk("R13 bank stays idle", 32'(bs(0)), 0);
    nop();
    chk("R9 refresh hold", 32'(dev_state), 3);
    nop();
    chk("R9 refresh last", 32'(dev_state), 3);
    nop();
    chk("R9 refresh done", 32'(dev_state), 0);

    // R8: extended register and bad bank select
    mrs(2'd1, 13'h0ab5);
    chk("R8 mode_ext written", 32'(mode_ext), 32'h0ab5);
    chk("R8 mode_std kept", 32'(mode_std), 4);
    nop();
    nop();
    chk("R8 ready again", 32'(dev_state), 0);
    mrs(2'd2, 13'h0002);
    chk("R12 err bad bank select", 32'(cmd_err), 1);
    chk("R12 dev ready", 32'(dev_state), 0);

    // R11: self refresh and deep power-down
    cke = 1'b0;
    refc();
    chk("R11 self refresh", 32'(dev_state), 4);
    nop();
    chk("R11 self refresh hold", 32'(dev_state), 4);
    cke = 1'b1;
    nop();
    chk("R11 self refresh exit", 32'(dev_state), 0);
    cke = 1'b0;
    bst();
    chk("R11 deep power-down", 32'(dev_state), 5);
    nop();
    chk("R11 deep power-down hold", 32'(dev_state), 5);
    cke = 1'b1;
    nop();
    chk("R11 deep power-down exit", 32'(dev_state), 0);

    // R12: illegal power-down entry while a burst runs
    act(2'd3, 13'h0042);
    rd(2'd3, 1'b0);
    cke = 1'b0;
    nop();
    chk("R12 err entry during burst", 32'(cmd_err), 1);
    chk("R12 dev stays ready", 32'(dev_state), 0);
    cke = 1'b1;
    repeat (10) nop();
    chk("R4 burst finished", 32'(bs(3)), 1);

    finish_run();
  end

endmodule